// File: doc/BRIEF.md
# Xon/Xoff Flow Control Controller

This block is the in-band flow-control engine of one serial channel. It watches four kinds of input: single-cycle pulses that say the receive path has just matched an Xon or an Xoff character, the current fill level of the receive FIFO, host command strobes, and an end-of-character strobe from the transmitter. From these it drives a transmit gate that allows or holds back new data characters. It also drives a one-entry request that asks the transmitter to insert an Xon or an Xoff character into its outgoing stream.

A 2-bit mode input holds two enables. Bit 0 lets received Xon/Xoff characters gate the transmitter (auto transmit). Bit 1 makes the block request Xoff and Xon on its own when the receive FIFO crosses fixed fill levels (auto receive). With both bits clear (host mode, the reset value in the surrounding channel), only host commands act. A host-forced Xoff stays in force until a dedicated resume command or a reset. Received Xon characters cannot release it.

The transmitter consumes the insertion request at its next character boundary, ahead of the next FIFO data byte, and answers with an acknowledge strobe. Requests are not held back by the stopped state.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset the transmit gate is open (`tx_gate_o` = 1) and no insertion is requested (`ins_req_o` = 0).
- R2: `mode_i` bit 0 enables auto transmit and bit 1 enables auto receive (00 host, 01 auto transmit, 10 auto receive, 11 both). In host mode, received Xon/Xoff pulses do not change the gate, and the fill level never raises a request.
- R3: In auto transmit, an `rx_xoff_i` pulse sets a pending stop. The gate closes in the cycle after the first `tx_eoc_i` strobe that comes in a later cycle than the pulse. A strobe in the same cycle as the pulse does not close it.
- R4: In auto transmit, when no host lock is in force, an `rx_xon_i` pulse opens the gate from the next cycle and cancels a pending stop. When both pulses arrive in one cycle, the Xoff takes effect.
- R5: Command code 10010 (force Xoff, accepted in every mode) stops the transmitter through the same pending-stop path as a received Xoff, and it sets a host lock.
- R6: While the host lock is set, received Xon has no effect. Command code 10110 (resume) clears the stop, the pending stop and the lock, so the gate is open in the next cycle.
- R7: Command code 10000 loads a send-Xon request and code 10001 a send-Xoff request. From the next cycle `ins_req_o` = 1, and `ins_is_xoff_o` is 1 for Xoff and 0 for Xon. Repeating the same command changes nothing. The opposite command replaces a request that has not yet been taken.
- R8: An `ins_ack_i` strobe clears the request from the next cycle. A request that is loaded in the same cycle as an acknowledge stays pending.
- R9: In auto receive, a send-Xoff request is loaded once when the fill level is at or above HI_LEVEL (default 48) and no Xoff is outstanding. This marks an Xoff as sent.
- R10: In auto receive, a send-Xon request is loaded once when the fill level is at or below LO_LEVEL (default 16), and only if an Xoff was sent before. Leaving auto receive forgets the sent Xoff.
- R11: Insertion requests are raised and held while the transmit gate is closed.
- R12: A host send command in the same cycle as a fill-level event wins. The fill-level event is taken in a later cycle if its condition still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Flow-control mode (bit 0 auto transmit, bit 1 auto receive) |
| rx_xon_i | input | 1 | Pulse: an Xon character was recognised on receive |
| rx_xoff_i | input | 1 | Pulse: an Xoff character was recognised on receive |
| rx_fill_i | input | FILL_W | Receive FIFO fill level |
| cmd_valid_i | input | 1 | Host command strobe |
| cmd_code_i | input | 5 | Host command code |
| tx_eoc_i | input | 1 | Pulse: the transmitter finished a character |
| ins_ack_i | input | 1 | Pulse: the transmitter took the inserted character |
| tx_gate_o | output | 1 | 1 = transmitter may start new data characters |
| ins_req_o | output | 1 | An Xon/Xoff insertion is pending |
| ins_is_xoff_o | output | 1 | Kind of the pending insertion (1 = Xoff, 0 = Xon) |

## Verification
Some rules are checked by assertions on every cycle. The gate may close only after an end-of-character strobe. A resume opens it, and a locked stop stays closed until then. An acknowledge with no new load empties the request slot, and a request that is not touched keeps its kind. No Xon request comes out of the fill logic unless an Xoff was sent before. Other behaviour shows only in the bench's scenarios, which compare every cycle against a behavioural model. These cover the ordering of a received Xoff against the strobe in the same cycle and the cancelling of a pending stop by Xon. They also cover replacing one request with the opposite one, the single-shot threshold events as the fill rises and drains, and a host command that pushes a threshold event to a later cycle.

// File: rtl/xfc_pkg.sv
`timescale 1ns/1ps
package xfc_pkg;

    localparam int CMD_W = 5;

    // host command codes
    localparam logic [CMD_W-1:0] CMD_SEND_XON   = 5'b10000;
    localparam logic [CMD_W-1:0] CMD_SEND_XOFF  = 5'b10001;
    localparam logic [CMD_W-1:0] CMD_FORCE_XOFF = 5'b10010;
    localparam logic [CMD_W-1:0] CMD_RESUME     = 5'b10110;

    typedef enum logic [1:0] {
        MODE_HOST    = 2'b00,
        MODE_AUTO_TX = 2'b01,
        MODE_AUTO_RX = 2'b10,
        MODE_BOTH    = 2'b11
    } fc_mode_e;

    typedef struct packed {
        logic stopped;
        logic stop_pend;
        logic host_lock;
    } gate_st_t;

    typedef struct packed {
        logic busy;
        logic is_xoff;
        logic xoff_sent;
    } ins_st_t;

endpackage

// File: rtl/xfc_decode.sv
`timescale 1ns/1ps
module xfc_decode
    import xfc_pkg::*;
(
    input  logic [1:0]       mode_i,
    input  logic             cmd_valid_i,
    input  logic [CMD_W-1:0] cmd_code_i,
    output logic             auto_tx_o,
    output logic             auto_rx_o,
    output logic             send_xon_o,
    output logic             send_xoff_o,
    output logic             force_xoff_o,
    output logic             resume_o
);
    fc_mode_e mode;

    always_comb begin
        mode         = fc_mode_e'(mode_i);
        auto_tx_o    = (mode == MODE_AUTO_TX) || (mode == MODE_BOTH);
        auto_rx_o    = (mode == MODE_AUTO_RX) || (mode == MODE_BOTH);
        send_xon_o   = cmd_valid_i && (cmd_code_i == CMD_SEND_XON);
        send_xoff_o  = cmd_valid_i && (cmd_code_i == CMD_SEND_XOFF);
        force_xoff_o = cmd_valid_i && (cmd_code_i == CMD_FORCE_XOFF);
        resume_o     = cmd_valid_i && (cmd_code_i == CMD_RESUME);
    end
endmodule

// File: rtl/xfc_gate.sv
`timescale 1ns/1ps
module xfc_gate
    import xfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_tx_i,
    input  logic rx_xon_i,
    input  logic rx_xoff_i,
    input  logic force_i,
    input  logic resume_i,
    input  logic eoc_i,
    output logic gate_o
);
    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (resume_i) begin
            st_d = '0;
        end else begin
            // a stop that was already pending takes effect at this boundary
            if (st_q.stop_pend && eoc_i) begin
                st_d.stopped   = 1'b1;
                st_d.stop_pend = 1'b0;
            end
            if (force_i) begin
                st_d.host_lock = 1'b1;
                if (!st_d.stopped) st_d.stop_pend = 1'b1;
            end else if (auto_tx_i && rx_xoff_i) begin
                if (!st_d.stopped) st_d.stop_pend = 1'b1;
            end else if (auto_tx_i && rx_xon_i && !st_q.host_lock) begin
                st_d.stopped   = 1'b0;
                st_d.stop_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_o = !st_q.stopped;

    // R3: the gate only closes right after a character boundary
    a_r3_close_on_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_o) |-> $past(eoc_i));

    // R4: unlocked Xon in auto transmit opens the gate
    a_r4_xon_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_tx_i && rx_xon_i && !rx_xoff_i && !force_i && !st_q.host_lock) |=> gate_o);

    // R5: force Xoff arms the pending stop and the lock
    a_r5_force_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && !resume_i && gate_o && !st_q.stop_pend) |=> (st_q.stop_pend && st_q.host_lock));

    // R6: a locked stop holds until resume
    a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.host_lock && !gate_o && !resume_i) |=> !gate_o);

    // R6: resume clears everything
    a_r6_resume_opens: assert property (@(posedge clk) disable iff (!rst_n)
        resume_i |=> (gate_o && !st_q.stop_pend && !st_q.host_lock));
endmodule

// File: rtl/xfc_insert.sv
`timescale 1ns/1ps
module xfc_insert
    import xfc_pkg::*;
#(
    parameter int FILL_W   = 6,
    parameter int HI_LEVEL = 48,
    parameter int LO_LEVEL = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_rx_i,
    input  logic [FILL_W-1:0] fill_i,
    input  logic              send_xon_i,
    input  logic              send_xoff_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic              is_xoff_o
);
    localparam logic [FILL_W-1:0] HI_FILL = HI_LEVEL[FILL_W-1:0];
    localparam logic [FILL_W-1:0] LO_FILL = LO_LEVEL[FILL_W-1:0];

    ins_st_t st_d, st_q;
    logic    at_high, at_low;

    always_comb begin
        at_high = auto_rx_i && !st_q.xoff_sent && (fill_i >= HI_FILL);
        at_low  = auto_rx_i &&  st_q.xoff_sent && (fill_i <= LO_FILL);
        st_d    = st_q;
        if (ack_i) st_d.busy = 1'b0;
        if (send_xon_i) begin
            st_d.busy    = 1'b1;
            st_d.is_xoff = 1'b0;
        end else if (send_xoff_i) begin
            st_d.busy    = 1'b1;
            st_d.is_xoff = 1'b1;
        end else if (at_high) begin
            st_d.busy      = 1'b1;
            st_d.is_xoff   = 1'b1;
            st_d.xoff_sent = 1'b1;
        end else if (at_low) begin
            st_d.busy      = 1'b1;
            st_d.is_xoff   = 1'b0;
            st_d.xoff_sent = 1'b0;
        end
        if (!auto_rx_i) st_d.xoff_sent = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o     = st_q.busy;
    assign is_xoff_o = st_q.is_xoff;

    // R8: an acknowledge with no new load empties the slot
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !send_xon_i && !send_xoff_i && !auto_rx_i) |=> !req_o);

    // R7: an untouched request keeps its kind
    a_r7_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i && !send_xon_i && !send_xoff_i && !auto_rx_i) |=> (req_o && $stable(is_xoff_o)));

    // R9: high fill with no Xoff outstanding loads an Xoff request
    a_r9_high_xoff: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rx_i && !st_q.xoff_sent && (fill_i >= HI_FILL) && !send_xon_i && !send_xoff_i)
        |=> (req_o && is_xoff_o && st_q.xoff_sent));

    // R10: no Xon appears from an idle slot unless an Xoff was sent before
    a_r10_no_stray_xon: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && !st_q.xoff_sent && !send_xon_i) |=> !(req_o && !is_xoff_o));
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
`timescale 1ns/1ps
module xonxoff_flow_ctrl
    import xfc_pkg::*;
#(
    parameter int FILL_W   = 6,
    parameter int HI_LEVEL = 48,
    parameter int LO_LEVEL = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              rx_xon_i,
    input  logic              rx_xoff_i,
    input  logic [FILL_W-1:0] rx_fill_i,
    input  logic              cmd_valid_i,
    input  logic [4:0]        cmd_code_i,
    input  logic              tx_eoc_i,
    input  logic              ins_ack_i,
    output logic              tx_gate_o,
    output logic              ins_req_o,
    output logic              ins_is_xoff_o
);
    logic auto_tx, auto_rx, send_xon, send_xoff, force_xoff, resume;

    xfc_decode i_decode (
        .mode_i       (mode_i),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_code_i   (cmd_code_i),
        .auto_tx_o    (auto_tx),
        .auto_rx_o    (auto_rx),
        .send_xon_o   (send_xon),
        .send_xoff_o  (send_xoff),
        .force_xoff_o (force_xoff),
        .resume_o     (resume)
    );

    xfc_gate i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_tx_i (auto_tx),
        .rx_xon_i  (rx_xon_i),
        .rx_xoff_i (rx_xoff_i),
        .force_i   (force_xoff),
        .resume_i  (resume),
        .eoc_i     (tx_eoc_i),
        .gate_o    (tx_gate_o)
    );

    xfc_insert #(
        .FILL_W   (FILL_W),
        .HI_LEVEL (HI_LEVEL),
        .LO_LEVEL (LO_LEVEL)
    ) i_insert (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_rx_i   (auto_rx),
        .fill_i      (rx_fill_i),
        .send_xon_i  (send_xon),
        .send_xoff_i (send_xoff),
        .ack_i       (ins_ack_i),
        .req_o       (ins_req_o),
        .is_xoff_o   (ins_is_xoff_o)
    );

    // R11: a closed gate never withdraws a pending request by itself
    a_r11_req_while_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_gate_o && ins_req_o && !ins_ack_i) |=> ins_req_o);
endmodule

// File: tb/test_xonxoff_flow_ctrl.sv
`timescale 1ns/1ps
module test_xonxoff_flow_ctrl;
    localparam int FW = 6;
    localparam int HI = 48;
    localparam int LO = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic          rx_xon = 0, rx_xoff = 0, cv = 0, eoc = 0, ack = 0;
    logic [FW-1:0] fill = '0;
    logic [4:0]    code = '0;
    logic          gate, req, kind;

    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;
    string tag = "R1";

    // reference state
    bit m_stop, m_pend, m_lock, m_busy, m_kind, m_sent;

    always #2 clk = ~clk;

    xonxoff_flow_ctrl #(.FILL_W(FW), .HI_LEVEL(HI), .LO_LEVEL(LO)) i_xonxoff_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .rx_xon_i(rx_xon), .rx_xoff_i(rx_xoff),
        .rx_fill_i(fill), .cmd_valid_i(cv), .cmd_code_i(code), .tx_eoc_i(eoc),
        .ins_ack_i(ack), .tx_gate_o(gate), .ins_req_o(req), .ins_is_xoff_o(kind));

    // behavioural reference, updated on the same edges as the design
    always @(posedge clk) begin
        bit is_cmd_xon, is_cmd_xoff, is_force, is_resume, atx, arx;
        int f;
        is_cmd_xon  = cv && code == 5'b10000;
        is_cmd_xoff = cv && code == 5'b10001;
        is_force    = cv && code == 5'b10010;
        is_resume   = cv && code == 5'b10110;
        atx = mode[0];
        arx = mode[1];
        f = int'(fill);
        if (!rst_n) begin
            {m_stop, m_pend, m_lock, m_busy, m_kind, m_sent} = '0;
        end else begin
            // transmit stop side
            if (is_resume) begin
                m_stop = 0; m_pend = 0; m_lock = 0;
            end else begin
                if (m_pend && eoc) begin m_stop = 1; m_pend = 0; end
                if (is_force) begin
                    m_lock = 1;
                    if (!m_stop) m_pend = 1;
                end else if (atx && rx_xoff) begin
                    if (!m_stop) m_pend = 1;
                end else if (atx && rx_xon && !m_lock) begin
                    m_stop = 0; m_pend = 0;
                end
            end
            // insertion side
            if (ack) m_busy = 0;
            if (is_cmd_xon)       begin m_busy = 1; m_kind = 0; end
            else if (is_cmd_xoff) begin m_busy = 1; m_kind = 1; end
            else if (arx && !m_sent && f >= HI) begin m_busy = 1; m_kind = 1; m_sent = 1; end
            else if (arx &&  m_sent && f <= LO) begin m_busy = 1; m_kind = 0; m_sent = 0; end
            if (!arx) m_sent = 0;
        end
    end

    task automatic compare();
        n_cmp++;
        if (gate !== !m_stop || req !== m_busy || (m_busy && kind !== m_kind)) begin
            n_bad++;
            $display("FAIL %s t=%0t gate/req/kind actual=%b%b%b expected=%b%b%b",
                     tag, $time, gate, req, kind, !m_stop, m_busy, m_kind);
        end
    endtask

    task automatic check(input string r, input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b", r, what, act, exp);
        end
    endtask

    // one clock: inputs held, edge, then sample at the falling edge and clear strobes
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
        rx_xon = 0; rx_xoff = 0; cv = 0; eoc = 0; ack = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic cmd(input logic [4:0] c);
        cv = 1; code = c; tick();
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        tick();
        tag = "R1";
        check("R1", gate, 1'b1, "gate after reset");
        check("R1", req, 1'b0, "request after reset");

        // host mode ignores received characters and fill
        tag = "R2"; mode = 2'b00;
        rx_xoff = 1; tick(); eoc = 1; tick(); idle(1);
        check("R2", gate, 1'b1, "host mode ignores rx xoff");
        fill = 6'd60; idle(2);
        check("R2", req, 1'b0, "host mode ignores fill");
        fill = 6'd20;

        // auto transmit: boundary ordering
        tag = "R3"; mode = 2'b01;
        rx_xoff = 1; eoc = 1; tick();
        check("R3", gate, 1'b1, "same-cycle eoc does not stop");
        idle(2);
        check("R3", gate, 1'b1, "gate open while pending");
        eoc = 1; tick();
        check("R3", gate, 1'b0, "gate closed after eoc");
        tag = "R4";
        rx_xon = 1; tick();
        check("R4", gate, 1'b1, "xon reopens");
        rx_xoff = 1; tick(); rx_xon = 1; tick(); eoc = 1; tick();
        check("R4", gate, 1'b1, "xon cancels pending stop");
        rx_xoff = 1; rx_xon = 1; tick(); eoc = 1; tick();
        check("R4", gate, 1'b0, "xoff wins same cycle");
        rx_xon = 1; tick();

        // host forced xoff with lock
        tag = "R5";
        cmd(5'b10010); idle(1);
        check("R5", gate, 1'b1, "force waits for boundary");
        eoc = 1; tick();
        check("R5", gate, 1'b0, "forced stop");
        tag = "R6";
        rx_xon = 1; tick(); idle(1);
        check("R6", gate, 1'b0, "xon ignored under lock");
        mode = 2'b00; idle(1); mode = 2'b01; idle(1);
        check("R6", gate, 1'b0, "mode toggle does not release");
        cmd(5'b10110);
        check("R6", gate, 1'b1, "resume reopens");

        // host send commands
        tag = "R7"; mode = 2'b00;
        cmd(5'b10001);
        check("R7", req, 1'b1, "send xoff request");
        check("R7", kind, 1'b1, "send xoff kind");
        cmd(5'b10001);
        check("R7", kind, 1'b1, "repeat harmless");
        cmd(5'b10000);
        check("R7", kind, 1'b0, "xon replaces xoff");
        cmd(5'b00011); idle(1);
        check("R7", req, 1'b1, "unknown code ignored");
        tag = "R8";
        ack = 1; tick();
        check("R8", req, 1'b0, "ack clears");
        cmd(5'b10000); ack = 1; cv = 1; code = 5'b10001; tick();
        check("R8", req, 1'b1, "load with ack stays");
        check("R8", kind, 1'b1, "second request kind");
        ack = 1; tick();

        // auto receive thresholds
        tag = "R10"; mode = 2'b10; fill = 6'd10; idle(2);
        check("R10", req, 1'b0, "no xon without prior xoff");
        tag = "R9"; fill = 6'd47; idle(2);
        check("R9", req, 1'b0, "below high level");
        fill = 6'd48; tick();
        check("R9", req, 1'b1, "xoff at high level");
        check("R9", kind, 1'b1, "xoff kind");
        ack = 1; tick(); fill = 6'd63; idle(3);
        check("R9", req, 1'b0, "xoff sent once");
        tag = "R10"; fill = 6'd17; idle(2);
        check("R10", req, 1'b0, "above low level");
        fill = 6'd16; tick();
        check("R10", req, 1'b1, "xon at low level");
        check("R10", kind, 1'b0, "xon kind");
        ack = 1; tick(); fill = 6'd0; idle(2);
        check("R10", req, 1'b0, "xon sent once");

        // requests while stopped
        tag = "R11"; mode = 2'b01;
        cmd(5'b10010); eoc = 1; tick();
        cmd(5'b10000); idle(3);
        check("R11", gate, 1'b0, "still stopped");
        check("R11", req, 1'b1, "request while stopped");
        ack = 1; tick(); cmd(5'b10110);

        // host command beats threshold event
        tag = "R12"; mode = 2'b10; fill = 6'd50;
        cv = 1; code = 5'b10000; tick();
        check("R12", kind, 1'b0, "host command first");
        tick();
        check("R12", kind, 1'b1, "threshold event later");
        ack = 1; tick();

        // mixed random traffic, compared every cycle
        tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            int r;
            if ((i % 300) == 0) mode = 2'($urandom_range(0, 3));
            r = $urandom_range(0, 99);
            rx_xon  = (r < 6);
            rx_xoff = (r >= 6 && r < 12);
            eoc     = ($urandom_range(0, 3) == 0);
            ack     = req && ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 9) == 0) begin
                cv = 1;
                case ($urandom_range(0, 4))
                    0: code = 5'b10000;
                    1: code = 5'b10001;
                    2: code = 5'b10010;
                    3: code = 5'b10110;
                    default: code = 5'b00011;
                endcase
            end
            if (fill < 6'd62 && $urandom_range(0, 1) == 1) fill = fill + 6'd2;
            else if (fill > 6'd1) fill = fill - 6'd2;
            tick();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule